// File: doc/BRIEF.md
# Descriptor Reference Ring Queue

The block keeps a circular queue of 14-bit descriptor references in an internal slot store. The ring covers a programmable window of slots, from a start index to an end index. A producer port pushes references. It stores each one at the write pointer and then moves that pointer forward. A consumer port pops references. It first moves the read pointer forward and then returns the reference held at the new read position. Both pointers wrap from the end index back to the start index.

Each popped reference is also turned into a byte address for its descriptor. The block shifts the reference by the 32-byte descriptor size and adds a programmable table base. Software can read and write the start, end, write and read pointers and the table base through a small register port. The same port reads the sticky error flags and clears them.

One slot always stays unused. The queue is empty when the slot after the read pointer is the write pointer. It is full when the two pointers are equal.

Top module: `drq_ring_queue`

## Requirements
- R1: After reset the start index is 0, the end index is 63 (the last slot), the read pointer is 0, the write pointer is 1, the table base is 0, both error flags are clear, `q_empty` is 1, `q_full` is 0 and `pop_valid` is 0.
- R2: An accepted push (`push_ok` high) stores `push_ref` in the slot at the write pointer. On the next clock edge the write pointer moves to its successor.
- R3: An accepted pop moves the read pointer to its successor. In the next cycle `pop_valid` is 1 and `pop_ref` holds the reference stored in that new slot.
- R4: The successor of a pointer equal to the end index is the start index. For any other pointer it is the pointer plus one.
- R5: `q_empty` is 1 when the successor of the read pointer equals the write pointer. A pop while empty is refused: no pointer moves and `pop_valid` stays 0. It also sets the underflow flag, which is status bit 1.
- R6: `q_full` is 1 when the write pointer equals the read pointer. A push while full is refused: `push_ok` is 0 and the write pointer and stored data are unchanged. It also sets the overflow flag, which is status bit 0.
- R7: Both error flags stay set until software writes the status register with a 1 in the flag's bit position.
- R8: While `pop_valid` is 1, `pop_addr` equals the table base plus 32 times `pop_ref`, modulo 2^32.
- R9: The register map is: index 0 start, 1 end, 2 write pointer, 3 read pointer, 4 table base, 5 status. Pointer registers sit in the low 6 bits. A register write takes effect at the next edge.
- R10: In a cycle with `reg_we` high, any push or pop is ignored. `push_ok` is 0, and no error flag is set by that push or pop.
- R11: A push and a pop in the same cycle are both accepted when the queue is neither full nor empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push | input | 1 | Producer request to enqueue `push_ref` |
| push_ref | input | 14 | Reference to enqueue |
| push_ok | output | 1 | Push accepted this cycle |
| pop | input | 1 | Consumer request to dequeue |
| pop_valid | output | 1 | `pop_ref` and `pop_addr` carry a dequeued reference |
| pop_ref | output | 14 | Dequeued reference |
| pop_addr | output | 32 | Descriptor byte address for `pop_ref` |
| q_empty | output | 1 | Queue holds no reference |
| q_full | output | 1 | Queue holds as many references as the ring allows |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |

## Verification
The assertions assume that software keeps the start index strictly below the end index. They also assume that both pointers lie inside that window. Outside those conditions the full and empty tests are not meaningful. The stimulus sets up each window through the register port only while the queue is idle. It loads the pointers as an empty queue (write pointer one past the read pointer). It never drives a register write together with a push or pop, except in the directed check of that priority rule. The random phase drives push and pop freely within an 8-slot window, so fill, drain, wrap and both refusal cases all occur.

// File: rtl/drq_pkg.sv
package drq_pkg;
    localparam int REF_W = 14;

    typedef enum logic [2:0] {
        RG_START = 3'd0,
        RG_END   = 3'd1,
        RG_WPTR  = 3'd2,
        RG_RPTR  = 3'd3,
        RG_BASE  = 3'd4,
        RG_STAT  = 3'd5
    } reg_sel_e;

    localparam int STAT_OVF = 0;
    localparam int STAT_UNF = 1;
endpackage

// File: rtl/drq_ring_step.sv
// Successor of a ring pointer inside the window [lo, hi].
module drq_ring_step #(
    parameter int PTR_W = 6
) (
    input  logic [PTR_W-1:0] cur,
    input  logic [PTR_W-1:0] lo,
    input  logic [PTR_W-1:0] hi,
    output logic [PTR_W-1:0] nxt
);
    always_comb begin
        if (cur == hi) nxt = lo;
        else           nxt = cur + PTR_W'(1);
    end
endmodule

// File: rtl/drq_ref_store.sv
// Slot storage: one write port, one registered read port.
module drq_ref_store #(
    parameter int PTR_W = 6,
    parameter int REF_W = 14
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [REF_W-1:0] wdata,
    input  logic             re,
    input  logic [PTR_W-1:0] raddr,
    output logic [REF_W-1:0] rdata
);
    localparam int DEPTH = 1 << PTR_W;

    logic [REF_W-1:0] slots [DEPTH];
    logic [REF_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) slots[waddr] <= wdata;
        if (re) rdata_q <= slots[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/drq_addr_map.sv
// Reference to descriptor byte address: base + ref * descriptor size.
module drq_addr_map #(
    parameter int ADDR_W = 32,
    parameter int REF_W  = 14,
    parameter int SHIFT  = 5
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [REF_W-1:0]  dref,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = ADDR_W'(dref) << SHIFT;
        addr   = base + offset;
    end
endmodule

// File: rtl/drq_ring_queue.sv
module drq_ring_queue
    import drq_pkg::*;
#(
    parameter int PTR_W      = 6,
    parameter int ADDR_W     = 32,
    parameter int DESC_BYTES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  logic [REF_W-1:0]     push_ref,
    output logic                 push_ok,
    input  logic                 pop,
    output logic                 pop_valid,
    output logic [REF_W-1:0]     pop_ref,
    output logic [ADDR_W-1:0]    pop_addr,
    output logic                 q_empty,
    output logic                 q_full,
    input  logic                 reg_we,
    input  logic [2:0]           reg_addr,
    input  logic [ADDR_W-1:0]    reg_wdata,
    output logic [ADDR_W-1:0]    reg_rdata
);
    localparam int DEPTH    = 1 << PTR_W;
    localparam int DESC_SH  = $clog2(DESC_BYTES);
    localparam int PAD_W    = ADDR_W - PTR_W;

    typedef struct packed {
        logic [PTR_W-1:0]  lo;
        logic [PTR_W-1:0]  hi;
        logic [PTR_W-1:0]  wr;
        logic [PTR_W-1:0]  rd;
        logic [ADDR_W-1:0] base;
        logic              ovf;
        logic              unf;
        logic              pop_vld;
    } state_t;

    state_t st_d, st_q;

    logic [PTR_W-1:0] wr_succ, rd_succ;
    logic             push_go, pop_go;
    logic             full_w, empty_w;

    // Plain views of the pointer state for the bound checker.
    logic [PTR_W-1:0] wr_ptr, rd_ptr, lo_ptr, hi_ptr;
    logic             ovf_flag, unf_flag;

    drq_ring_step #(.PTR_W(PTR_W)) u_wr_step (
        .cur(st_q.wr), .lo(st_q.lo), .hi(st_q.hi), .nxt(wr_succ)
    );

    drq_ring_step #(.PTR_W(PTR_W)) u_rd_step (
        .cur(st_q.rd), .lo(st_q.lo), .hi(st_q.hi), .nxt(rd_succ)
    );

    assign full_w  = (st_q.wr == st_q.rd);
    assign empty_w = (rd_succ == st_q.wr);
    assign push_go = push && !full_w && !reg_we;
    assign pop_go  = pop && !empty_w && !reg_we;

    drq_ref_store #(.PTR_W(PTR_W), .REF_W(REF_W)) u_store (
        .clk   (clk),
        .we    (push_go),
        .waddr (st_q.wr),
        .wdata (push_ref),
        .re    (pop_go),
        .raddr (rd_succ),
        .rdata (pop_ref)
    );

    drq_addr_map #(.ADDR_W(ADDR_W), .REF_W(REF_W), .SHIFT(DESC_SH)) u_map (
        .base (st_q.base),
        .dref (pop_ref),
        .addr (pop_addr)
    );

    // Next-state logic
    always_comb begin
        st_d         = st_q;
        st_d.pop_vld = 1'b0;
        if (reg_we) begin
            case (reg_addr)
                RG_START: st_d.lo   = reg_wdata[PTR_W-1:0];
                RG_END:   st_d.hi   = reg_wdata[PTR_W-1:0];
                RG_WPTR:  st_d.wr   = reg_wdata[PTR_W-1:0];
                RG_RPTR:  st_d.rd   = reg_wdata[PTR_W-1:0];
                RG_BASE:  st_d.base = reg_wdata;
                RG_STAT: begin
                    if (reg_wdata[STAT_OVF]) st_d.ovf = 1'b0;
                    if (reg_wdata[STAT_UNF]) st_d.unf = 1'b0;
                end
                default: ;
            endcase
        end else begin
            if (push_go)   st_d.wr  = wr_succ;
            else if (push) st_d.ovf = 1'b1;
            if (pop_go) begin
                st_d.rd      = rd_succ;
                st_d.pop_vld = 1'b1;
            end else if (pop) begin
                st_d.unf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.hi      <= PTR_W'(DEPTH - 1);
            st_q.wr      <= PTR_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    // Register read mux
    always_comb begin
        case (reg_addr)
            RG_START: reg_rdata = {{PAD_W{1'b0}}, st_q.lo};
            RG_END:   reg_rdata = {{PAD_W{1'b0}}, st_q.hi};
            RG_WPTR:  reg_rdata = {{PAD_W{1'b0}}, st_q.wr};
            RG_RPTR:  reg_rdata = {{PAD_W{1'b0}}, st_q.rd};
            RG_BASE:  reg_rdata = st_q.base;
            RG_STAT:  reg_rdata = {{(ADDR_W-2){1'b0}}, st_q.unf, st_q.ovf};
            default:  reg_rdata = '0;
        endcase
    end

    assign push_ok   = push_go;
    assign pop_valid = st_q.pop_vld;
    assign q_full    = full_w;
    assign q_empty   = empty_w;

    assign wr_ptr   = st_q.wr;
    assign rd_ptr   = st_q.rd;
    assign lo_ptr   = st_q.lo;
    assign hi_ptr   = st_q.hi;
    assign ovf_flag = st_q.ovf;
    assign unf_flag = st_q.unf;
endmodule

// File: rtl/drq_ring_queue_chk.sv
module drq_ring_queue_chk #(
    parameter int PTR_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push,
    input logic             pop,
    input logic             reg_we,
    input logic [2:0]       reg_addr,
    input logic [1:0]       clr_bits,
    input logic             push_ok,
    input logic             pop_valid,
    input logic             q_full,
    input logic             q_empty,
    input logic [PTR_W-1:0] wr_ptr,
    input logic [PTR_W-1:0] rd_ptr,
    input logic [PTR_W-1:0] lo_ptr,
    input logic [PTR_W-1:0] hi_ptr,
    input logic             ovf_flag,
    input logic             unf_flag
);
    logic clr_ovf, clr_unf;
    assign clr_ovf = reg_we && (reg_addr == 3'd5) && clr_bits[0];
    assign clr_unf = reg_we && (reg_addr == 3'd5) && clr_bits[1];

    // R2: an accepted push moves the write pointer
    p_push_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && (lo_ptr < hi_ptr)) |=> (wr_ptr != $past(wr_ptr)));

    // R3: an accepted pop yields a valid result next cycle
    p_pop_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !q_empty && !reg_we) |=> pop_valid);

    // R5: pop on empty refused and flagged
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && q_empty && !reg_we) |=> (!pop_valid && unf_flag && $stable(rd_ptr)));

    // R6: push on full refused and flagged
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && q_full && !reg_we) |=> ($stable(wr_ptr) && ovf_flag));

    // R6: a refused push is never acknowledged
    p_full_no_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !push_ok);

    // R7: flags are sticky until cleared
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr_ovf) |=> ovf_flag);
    p_unf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_flag && !clr_unf) |=> unf_flag);

    // R10: register writes take priority over push
    p_reg_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !push_ok);

    // R5/R6: full and empty exclude each other on a proper window
    p_full_empty_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_ptr < hi_ptr) |-> !(q_full && q_empty));
endmodule

bind drq_ring_queue drq_ring_queue_chk #(.PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .pop       (pop),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .clr_bits  (reg_wdata[1:0]),
    .push_ok   (push_ok),
    .pop_valid (pop_valid),
    .q_full    (q_full),
    .q_empty   (q_empty),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .lo_ptr    (lo_ptr),
    .hi_ptr    (hi_ptr),
    .ovf_flag  (ovf_flag),
    .unf_flag  (unf_flag)
);

// File: tb/drq_ring_queue_tb.sv
module drq_ring_queue_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        push, pop, reg_we;
    logic [13:0] push_ref;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic        push_ok, pop_valid, q_empty, q_full;
    logic [13:0] pop_ref;
    logic [31:0] pop_addr, reg_rdata;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // model state
    logic [13:0] m_mem [64];
    logic [5:0]  m_lo, m_hi, m_wr, m_rd;
    logic [31:0] m_base;
    bit          m_ovf, m_unf;

    always #10 clk = ~clk;

    drq_ring_queue u_dut (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_ref(push_ref), .push_ok(push_ok),
        .pop(pop), .pop_valid(pop_valid), .pop_ref(pop_ref), .pop_addr(pop_addr),
        .q_empty(q_empty), .q_full(q_full),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    function automatic logic [5:0] succ(input logic [5:0] p);
        return (p == m_hi) ? m_lo : p + 6'd1;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rdreg(input logic [2:0] idx, input logic [31:0] exp, input string tag);
        reg_addr = idx;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    // One cycle; called just after a falling edge.
    task automatic step(input bit pu, input logic [13:0] rf, input bit po,
                        input bit we, input logic [2:0] ra, input logic [31:0] wd);
        bit          e_full, e_empty, e_pok, e_vld;
        logic [13:0] e_ref;
        push = pu; push_ref = rf; pop = po;
        reg_we = we; reg_addr = ra; reg_wdata = wd;
        #1;
        e_full  = (m_wr == m_rd);
        e_empty = (succ(m_rd) == m_wr);
        e_pok   = pu && !e_full && !we;
        chk("R6 q_full", {31'd0, q_full}, {31'd0, e_full});
        chk("R5 q_empty", {31'd0, q_empty}, {31'd0, e_empty});
        chk(we ? "R10 push_ok" : "R6 push_ok", {31'd0, push_ok}, {31'd0, e_pok});
        e_vld = 1'b0;
        e_ref = '0;
        @(posedge clk);
        if (we) begin
            case (ra)
                3'd0: m_lo = wd[5:0];
                3'd1: m_hi = wd[5:0];
                3'd2: m_wr = wd[5:0];
                3'd3: m_rd = wd[5:0];
                3'd4: m_base = wd;
                3'd5: begin
                    if (wd[0]) m_ovf = 1'b0;
                    if (wd[1]) m_unf = 1'b0;
                end
                default: ;
            endcase
        end else begin
            if (pu) begin
                if (!e_full) begin m_mem[m_wr] = rf; m_wr = succ(m_wr); end
                else m_ovf = 1'b1;
            end
            if (po) begin
                if (!e_empty) begin
                    m_rd = succ(m_rd); e_vld = 1'b1; e_ref = m_mem[m_rd];
                end else m_unf = 1'b1;
            end
        end
        @(negedge clk);
        push = 1'b0; pop = 1'b0; reg_we = 1'b0;
        #1;
        chk(e_vld ? "R3 pop_valid" : "R5 pop_valid", {31'd0, pop_valid}, {31'd0, e_vld});
        if (e_vld) begin
            chk("R3 pop_ref", {18'd0, pop_ref}, {18'd0, e_ref});
            chk("R8 pop_addr", pop_addr, m_base + ({18'd0, e_ref} << 5));
        end
    endtask

    task automatic check_regs(input string tag);
        rdreg(3'd0, {26'd0, m_lo}, tag);
        rdreg(3'd1, {26'd0, m_hi}, tag);
        rdreg(3'd2, {26'd0, m_wr}, tag);
        rdreg(3'd3, {26'd0, m_rd}, tag);
        rdreg(3'd4, m_base, tag);
        rdreg(3'd5, {30'd0, m_unf, m_ovf}, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d5e_ed42));
        push = 0; pop = 0; reg_we = 0; push_ref = '0; reg_addr = '0; reg_wdata = '0;
        rst_n = 1'b0;
        m_lo = 6'd0; m_hi = 6'd63; m_wr = 6'd1; m_rd = 6'd0;
        m_base = '0; m_ovf = 0; m_unf = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 empty", {31'd0, q_empty}, 32'd1);
        chk("R1 full", {31'd0, q_full}, 32'd0);
        chk("R1 pop_valid", {31'd0, pop_valid}, 32'd0);
        check_regs("R1 regs");

        // R5 underflow on empty queue
        step(0, 0, 1, 0, 0, 0);
        check_regs("R5 unf flag");
        // R7 sticky over idle cycles
        step(0, 0, 0, 0, 0, 0);
        check_regs("R7 sticky");
        // R9 table base, R8 conversion
        step(0, 0, 0, 1, 3'd4, 32'h8000_1000);
        // R2/R3 push then pop
        step(1, 14'h3fff, 0, 0, 0, 0);
        step(1, 14'h0123, 0, 0, 0, 0);
        check_regs("R2 wr advance");
        step(0, 0, 1, 0, 0, 0);
        step(1, 14'h0aaa, 1, 0, 0, 0);   // R11 simultaneous
        step(0, 0, 1, 0, 0, 0);
        check_regs("R3 rd advance");
        // R7 clear only overflow bit: unf stays
        step(0, 0, 0, 1, 3'd5, 32'd1);
        check_regs("R7 partial clear");
        step(0, 0, 0, 1, 3'd5, 32'd2);
        check_regs("R7 clear");

        // R9 small window 4..11, empty queue
        step(0, 0, 0, 1, 3'd0, 32'd4);
        step(0, 0, 0, 1, 3'd1, 32'd11);
        step(0, 0, 0, 1, 3'd3, 32'd4);
        step(0, 0, 0, 1, 3'd2, 32'd5);
        check_regs("R9 window");
        // R6 fill to full (7 slots), then overflow; R4 wrap
        for (int i = 0; i < 8; i++) step(1, 14'(16'h100 + i), 0, 0, 0, 0);
        check_regs("R6 ovf flag");
        // R10 register write with push and pop: both ignored, no flag change
        step(0, 0, 0, 1, 3'd5, 32'd3);
        step(1, 14'h0555, 1, 1, 3'd4, 32'h0000_4000);
        check_regs("R10 prio");
        // R4 drain across wrap
        for (int i = 0; i < 8; i++) step(0, 0, 1, 0, 0, 0);
        check_regs("R4 drained");
        step(0, 0, 0, 1, 3'd5, 32'd3);

        // random phase
        for (int i = 0; i < 600; i++) begin
            automatic int r = $urandom_range(0, 99);
            automatic bit pu = (r % 3) != 0;
            automatic bit po = ($urandom_range(0, 99) < 55);
            step(pu, 14'($urandom), po, 0, 0, 0);
            if ((i % 97) == 0) begin
                check_regs("R4 random regs");
                step(0, 0, 0, 1, 3'd5, 32'd3);
            end
        end
        check_regs("R2 final regs");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule